// File: doc/BRIEF.md
# Age-Ordered Instruction Issue Queue

This block holds renamed instructions until their operands are available and then hands them to execution, oldest first. Each inserted instruction carries an 8-bit sequence number, a class (integer, floating point, branch or miscellaneous), up to two physical source tags, one destination tag and a flag that marks it as non-speculative. A register readiness scoreboard covers the whole physical tag space. Integer registers occupy the low tag indices and floating-point registers follow directly above them. Allocating a destination marks its tag pending. A completion broadcast marks the tag ready again and wakes every queued consumer of that tag.

Every cycle the queue picks among its ready entries by age. Each class is limited in how many instructions it may issue per cycle, and a total limit applies across all classes. Issued instructions leave the queue and appear for one cycle on the issue slots. Non-speculative entries stay put until a commit release names their sequence number. A squash removes every entry younger than the given sequence number. The block reports its free entry count and a full flag.

Top module: `issue_queue_top`

## Requirements
- R1: After reset the free count equals the entry count (8), full is 0, no issue slot is valid, and every physical tag is ready.
- R2: An instruction inserted at rising edge k with ready operands appears on an issue slot after edge k+1. Each slot's valid lasts for exactly one cycle. Slot 0 always holds the older of the two issued instructions, and slot 1 is valid only when slot 0 is.
- R3: Class codes are 0 integer, 1 floating point, 2 branch and 3 miscellaneous. At most one instruction per class issues per cycle, and within a class the oldest ready entry goes first.
- R4: At most two instructions issue per cycle in total. When more than two class heads are ready, the two oldest issue. Age is wraparound-aware: a is older than b when (a-b) mod 256 is at least 128.
- R5: Inserting an instruction with a valid destination marks that tag pending. A consumer of a pending tag waits. A wakeup broadcast on the tag marks it ready and makes every waiting consumer of it issuable from the next edge.
- R6: A wakeup broadcast in the same cycle as an insert whose source reads the broadcast tag makes that source ready at insertion.
- R7: A non-speculative entry never issues on operand readiness alone. It becomes issuable only after a release whose sequence number equals its own. A release carrying any other number has no effect.
- R8: A squash with sequence number S removes every entry younger than S in that same edge, and none of those entries issues. Entries equal to or older than S remain. An insert in the squash cycle is dropped.
- R9: The free count equals 8 minus the number of held entries. Full is 1 exactly when the free count is 0. An insert while full is refused, and an entry's slot becomes free at the edge where it issues or is squashed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert request |
| ins_seq | input | 8 | Sequence number of the inserted instruction |
| ins_cls | input | 2 | Class code of the inserted instruction |
| ins_nonspec | input | 1 | Instruction waits for a commit release |
| ins_s0_valid | input | 1 | First source is used |
| ins_s0_tag | input | 5 | First source physical tag |
| ins_s1_valid | input | 1 | Second source is used |
| ins_s1_tag | input | 5 | Second source physical tag |
| ins_dst_valid | input | 1 | Destination is written |
| ins_dst_tag | input | 5 | Destination physical tag |
| wk_valid | input | 1 | Completion broadcast |
| wk_tag | input | 5 | Tag whose value has been produced |
| rel_valid | input | 1 | Commit release of a non-speculative instruction |
| rel_seq | input | 8 | Sequence number being released |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | 8 | Entries younger than this are removed |
| iss_valid | output | 2 | Per-slot issue valid |
| iss_seq | output | 16 | Per-slot sequence number, slot s at bits 8s+7..8s |
| iss_tag | output | 10 | Per-slot destination tag, slot s at bits 5s+4..5s |
| free_cnt | output | 4 | Number of empty entries |
| full | output | 1 | No entry is free |

## Verification
Queue contents, scoreboard, free count and full all change at the rising edge that takes an insert, wakeup, release or squash. The issue slots show the selection made from the contents held before an edge, and they become visible just after that edge. An instruction inserted at edge k can therefore issue after edge k+1 at the earliest, and a wakeup or release at edge k can first enable an issue after edge k+1. The bench drives all inputs during the low phase. Its reference model advances once per rising edge using the inputs held at that edge. Every output is compared against the model's prediction at the following falling edge, so each result is checked in the cycle it is due.

// File: rtl/iq_pkg.sv
package iq_pkg;
  parameter int SEQ_W    = 8;
  parameter int INT_REGS = 16;
  parameter int FP_REGS  = 16;
  localparam int PREGS   = INT_REGS + FP_REGS;
  localparam int TAG_W   = $clog2(PREGS);
  localparam int CLS_W   = 2;
  localparam int NCLS    = 1 << CLS_W;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT  = 2'd0,
    CLS_FP   = 2'd1,
    CLS_BR   = 2'd2,
    CLS_MISC = 2'd3
  } iq_cls_e;

  typedef struct packed {
    logic             valid;
    logic [SEQ_W-1:0] seq;
    iq_cls_e          cls;
    logic             nonspec;
    logic             released;
    logic [TAG_W-1:0] s0_tag;
    logic             s0_rdy;
    logic [TAG_W-1:0] s1_tag;
    logic             s1_rdy;
    logic [TAG_W-1:0] dst_tag;
  } iq_entry_t;

  // a is older than b under wraparound ordering
  function automatic logic seq_older(input logic [SEQ_W-1:0] a,
                                     input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] diff;
    diff = a - b;
    return diff[SEQ_W-1];
  endfunction
endpackage

// File: rtl/iq_scoreboard.sv
module iq_scoreboard
  import iq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wk_valid,
  input  logic [TAG_W-1:0] wk_tag,
  input  logic             alloc_valid,
  input  logic [TAG_W-1:0] alloc_tag,
  output logic [PREGS-1:0] rdy
);
  logic [PREGS-1:0] rdy_q, rdy_d;
  logic             rdy_en;

  always_comb begin
    rdy_d = rdy_q;
    if (wk_valid)    rdy_d[wk_tag]    = 1'b1;
    if (alloc_valid) rdy_d[alloc_tag] = 1'b0;
    rdy_en = wk_valid | alloc_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdy_q <= '1;
    else if (rdy_en) rdy_q <= rdy_d;
  end

  assign rdy = rdy_q;

  // R5: a broadcast leaves its tag ready unless re-allocated in the same cycle
  assert_wake_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_valid && !(alloc_valid && alloc_tag == wk_tag)) |=> rdy_q[$past(wk_tag)]);

  // R5: allocation leaves the destination pending
  assert_alloc_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |=> !rdy_q[$past(alloc_tag)]);
endmodule

// File: rtl/iq_entry.sv
module iq_entry
  import iq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  iq_entry_t        wr_data,
  input  logic             wk_valid,
  input  logic [TAG_W-1:0] wk_tag,
  input  logic             rel_valid,
  input  logic [SEQ_W-1:0] rel_seq,
  input  logic             sq_valid,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic             issue,
  output logic             o_valid,
  output logic [SEQ_W-1:0] o_seq,
  output logic [CLS_W-1:0] o_cls,
  output logic [TAG_W-1:0] o_dst,
  output logic             req
);
  iq_entry_t ent_q, ent_d;
  logic      ent_en;
  logic      kill;

  always_comb begin
    kill = ent_q.valid & sq_valid & seq_older(sq_seq, ent_q.seq);
    req  = ent_q.valid & ent_q.s0_rdy & ent_q.s1_rdy
         & (~ent_q.nonspec | ent_q.released) & ~kill;
  end

  always_comb begin
    ent_d = ent_q;
    if (wk_valid) begin
      if (ent_q.s0_tag == wk_tag) ent_d.s0_rdy = 1'b1;
      if (ent_q.s1_tag == wk_tag) ent_d.s1_rdy = 1'b1;
    end
    if (rel_valid && ent_q.nonspec && ent_q.seq == rel_seq) ent_d.released = 1'b1;
    if (issue || kill) ent_d.valid = 1'b0;
    if (wr_en) ent_d = wr_data;
    ent_en = wr_en | issue | kill | wk_valid | rel_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ent_q <= '0;
    else if (ent_en) ent_q <= ent_d;
  end

  assign o_valid = ent_q.valid;
  assign o_seq   = ent_q.seq;
  assign o_cls   = ent_q.cls;
  assign o_dst   = ent_q.dst_tag;

  // R9: a held entry is never overwritten by an insert
  assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !ent_q.valid);

  // R8: a squashed entry is gone after the edge
  assert_squash_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !ent_q.valid);

  // R7: the release mark only appears after a matching commit release
  assert_release_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ent_q.released) |-> ($past(rel_valid) && $past(rel_seq) == ent_q.seq));
endmodule

// File: rtl/iq_select.sv
module iq_select
  import iq_pkg::*;
#(
  parameter int N         = 8,
  parameter int ISSUE_W   = 2,
  parameter int CLASS_LIM = 1,
  localparam int CNT_W    = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic [SEQ_W-1:0] seq [N],
  input  logic [CLS_W-1:0] cls [N],
  output logic [N-1:0]     grant,
  output logic [N-1:0]     slot_oh [ISSUE_W]
);
  logic [CNT_W-1:0] same_cnt [N];
  logic [CNT_W-1:0] old_cnt  [N];
  logic [CNT_W-1:0] rank     [N];
  logic [N-1:0]     elig;

  always_comb begin
    // class heads: fewer than CLASS_LIM older ready entries in the same class
    for (int i = 0; i < N; i++) begin
      same_cnt[i] = '0;
      for (int j = 0; j < N; j++) begin
        if (j != i && req[j] && cls[j] == cls[i] && seq_older(seq[j], seq[i]))
          same_cnt[i] = same_cnt[i] + CNT_W'(1);
      end
      elig[i] = req[i] && (same_cnt[i] < CNT_W'(CLASS_LIM));
    end
    // total limit: fewer than ISSUE_W older class heads
    for (int i = 0; i < N; i++) begin
      old_cnt[i] = '0;
      for (int j = 0; j < N; j++) begin
        if (j != i && elig[j] && seq_older(seq[j], seq[i]))
          old_cnt[i] = old_cnt[i] + CNT_W'(1);
      end
      grant[i] = elig[i] && (old_cnt[i] < CNT_W'(ISSUE_W));
    end
    // slot order by age among the granted entries
    for (int i = 0; i < N; i++) begin
      rank[i] = '0;
      for (int j = 0; j < N; j++) begin
        if (j != i && grant[j] && seq_older(seq[j], seq[i]))
          rank[i] = rank[i] + CNT_W'(1);
      end
    end
    for (int s = 0; s < ISSUE_W; s++) begin
      for (int i = 0; i < N; i++) begin
        slot_oh[s][i] = grant[i] && (rank[i] == CNT_W'(s));
      end
    end
  end

  // R4: never more grants than the total width
  assert_total_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) <= ISSUE_W);

  // R3: per-class grant limit
  for (genvar c = 0; c < NCLS; c++) begin : g_cls_chk
    logic [N-1:0] cls_mask;
    always_comb begin
      for (int i = 0; i < N; i++) cls_mask[i] = (cls[i] == CLS_W'(c));
    end
    assert_class_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grant & cls_mask) <= CLASS_LIM);
  end
endmodule

// File: rtl/issue_queue_top.sv
module issue_queue_top
  import iq_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ISSUE_W     = 2,
  parameter int CLASS_LIM   = 1,
  localparam int CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ins_valid,
  input  logic [SEQ_W-1:0]         ins_seq,
  input  logic [CLS_W-1:0]         ins_cls,
  input  logic                     ins_nonspec,
  input  logic                     ins_s0_valid,
  input  logic [TAG_W-1:0]         ins_s0_tag,
  input  logic                     ins_s1_valid,
  input  logic [TAG_W-1:0]         ins_s1_tag,
  input  logic                     ins_dst_valid,
  input  logic [TAG_W-1:0]         ins_dst_tag,
  input  logic                     wk_valid,
  input  logic [TAG_W-1:0]         wk_tag,
  input  logic                     rel_valid,
  input  logic [SEQ_W-1:0]         rel_seq,
  input  logic                     sq_valid,
  input  logic [SEQ_W-1:0]         sq_seq,
  output logic [ISSUE_W-1:0]       iss_valid,
  output logic [ISSUE_W*SEQ_W-1:0] iss_seq,
  output logic [ISSUE_W*TAG_W-1:0] iss_tag,
  output logic [CNT_W-1:0]         free_cnt,
  output logic                     full
);
  logic [NUM_ENTRIES-1:0] vld, req, grant, wr_en;
  logic [SEQ_W-1:0]       e_seq [NUM_ENTRIES];
  logic [CLS_W-1:0]       e_cls [NUM_ENTRIES];
  logic [TAG_W-1:0]       e_dst [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] slot_oh [ISSUE_W];
  logic [PREGS-1:0]       sb_rdy;
  iq_entry_t              wr_data;
  logic                   accept, found;
  logic [CNT_W-1:0]       used_cnt;

  logic [ISSUE_W-1:0]     nxt_vld, iss_vld_q;
  logic [SEQ_W-1:0]       nxt_seq [ISSUE_W];
  logic [TAG_W-1:0]       nxt_tag [ISSUE_W];
  logic [SEQ_W-1:0]       iss_seq_q [ISSUE_W];
  logic [TAG_W-1:0]       iss_tag_q [ISSUE_W];
  logic                   iss_en;

  // occupancy
  always_comb begin
    used_cnt = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) used_cnt = used_cnt + CNT_W'(vld[i]);
    free_cnt = CNT_W'(NUM_ENTRIES) - used_cnt;
    full     = (free_cnt == '0);
  end

  // insert: refused when full or while a squash is applied
  assign accept = ins_valid & ~full & ~sq_valid;

  always_comb begin
    found = 1'b0;
    wr_en = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!vld[i] && !found) begin
        wr_en[i] = accept;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    wr_data          = '0;
    wr_data.valid    = 1'b1;
    wr_data.seq      = ins_seq;
    wr_data.cls      = iq_cls_e'(ins_cls);
    wr_data.nonspec  = ins_nonspec;
    wr_data.released = 1'b0;
    wr_data.s0_tag   = ins_s0_valid ? ins_s0_tag : '0;
    wr_data.s0_rdy   = ~ins_s0_valid | sb_rdy[ins_s0_tag] | (wk_valid & (wk_tag == ins_s0_tag));
    wr_data.s1_tag   = ins_s1_valid ? ins_s1_tag : '0;
    wr_data.s1_rdy   = ~ins_s1_valid | sb_rdy[ins_s1_tag] | (wk_valid & (wk_tag == ins_s1_tag));
    wr_data.dst_tag  = ins_dst_tag;
  end

  iq_scoreboard u_sb (
    .clk         (clk),
    .rst_n       (rst_n),
    .wk_valid    (wk_valid),
    .wk_tag      (wk_tag),
    .alloc_valid (accept & ins_dst_valid),
    .alloc_tag   (ins_dst_tag),
    .rdy         (sb_rdy)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    iq_entry u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en[g]),
      .wr_data   (wr_data),
      .wk_valid  (wk_valid),
      .wk_tag    (wk_tag),
      .rel_valid (rel_valid),
      .rel_seq   (rel_seq),
      .sq_valid  (sq_valid),
      .sq_seq    (sq_seq),
      .issue     (grant[g]),
      .o_valid   (vld[g]),
      .o_seq     (e_seq[g]),
      .o_cls     (e_cls[g]),
      .o_dst     (e_dst[g]),
      .req       (req[g])
    );
  end

  iq_select #(
    .N         (NUM_ENTRIES),
    .ISSUE_W   (ISSUE_W),
    .CLASS_LIM (CLASS_LIM)
  ) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .seq     (e_seq),
    .cls     (e_cls),
    .grant   (grant),
    .slot_oh (slot_oh)
  );

  // issue slot mux
  always_comb begin
    for (int s = 0; s < ISSUE_W; s++) begin
      nxt_vld[s] = 1'b0;
      nxt_seq[s] = '0;
      nxt_tag[s] = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (slot_oh[s][i]) begin
          nxt_vld[s] = 1'b1;
          nxt_seq[s] = nxt_seq[s] | e_seq[i];
          nxt_tag[s] = nxt_tag[s] | e_dst[i];
        end
      end
    end
    iss_en = |nxt_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) iss_vld_q <= '0;
    else        iss_vld_q <= nxt_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < ISSUE_W; s++) begin
        iss_seq_q[s] <= '0;
        iss_tag_q[s] <= '0;
      end
    end else if (iss_en) begin
      for (int s = 0; s < ISSUE_W; s++) begin
        iss_seq_q[s] <= nxt_seq[s];
        iss_tag_q[s] <= nxt_tag[s];
      end
    end
  end

  assign iss_valid = iss_vld_q;
  for (genvar s = 0; s < ISSUE_W; s++) begin : g_out
    assign iss_seq[s*SEQ_W +: SEQ_W] = iss_seq_q[s];
    assign iss_tag[s*TAG_W +: TAG_W] = iss_tag_q[s];
  end

  // R4: issued slots are packed and ordered oldest first
  assert_age_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[1] |-> (iss_valid[0] && seq_older(iss_seq[0 +: SEQ_W], iss_seq[SEQ_W +: SEQ_W])));

  // R8: no insert lands while squashing, so the free count cannot fall
  assert_squash_no_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |=> free_cnt >= $past(free_cnt));

  // R9: at most one insert per cycle
  assert_one_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(free_cnt) <= free_cnt + CNT_W'(1)));
endmodule

// File: tb/issue_queue_top_tb_top.sv
`timescale 1ns/1ps
module issue_queue_top_tb_top;
  import iq_pkg::*;
  localparam int N  = 8;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 0, ins_nonspec = 0, ins_s0_valid = 0, ins_s1_valid = 0, ins_dst_valid = 0;
  logic [7:0] ins_seq = 0;
  logic [1:0] ins_cls = 0;
  logic [4:0] ins_s0_tag = 0, ins_s1_tag = 0, ins_dst_tag = 0;
  logic wk_valid = 0, rel_valid = 0, sq_valid = 0;
  logic [4:0] wk_tag = 0;
  logic [7:0] rel_seq = 0, sq_seq = 0;
  logic [1:0]  iss_valid;
  logic [15:0] iss_seq;
  logic [9:0]  iss_tag;
  logic [3:0]  free_cnt;
  logic        full;

  issue_queue_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_seq(ins_seq), .ins_cls(ins_cls), .ins_nonspec(ins_nonspec),
    .ins_s0_valid(ins_s0_valid), .ins_s0_tag(ins_s0_tag),
    .ins_s1_valid(ins_s1_valid), .ins_s1_tag(ins_s1_tag),
    .ins_dst_valid(ins_dst_valid), .ins_dst_tag(ins_dst_tag),
    .wk_valid(wk_valid), .wk_tag(wk_tag), .rel_valid(rel_valid), .rel_seq(rel_seq),
    .sq_valid(sq_valid), .sq_seq(sq_seq),
    .iss_valid(iss_valid), .iss_seq(iss_seq), .iss_tag(iss_tag),
    .free_cnt(free_cnt), .full(full)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int seq; int cls; bit ns; bit rel; bit r0; bit r1; int t0; int t1; int dst;
  } ment_t;
  ment_t mq[$];
  bit    msb[PREGS];
  int    exp_n;
  int    exp_seq[IW];
  int    exp_tag[IW];

  function automatic bit older(int a, int b);
    return ((a - b) & 255) >= 128;
  endfunction

  task automatic check(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // reference model: one rising edge with the inputs currently driven
  task automatic model_step();
    int  cand[$];
    int  ccnt[4];
    bit  rm[N];
    bit  acc;
    ment_t e;
    acc = ins_valid && (mq.size() < N) && !sq_valid;
    for (int c = 0; c < 4; c++) ccnt[c] = 0;
    for (int i = 0; i < N; i++) rm[i] = 0;
    for (int i = 0; i < mq.size(); i++) begin
      bit k;
      k = sq_valid && older(int'(sq_seq), mq[i].seq);
      if (k) rm[i] = 1;
      else if (mq[i].r0 && mq[i].r1 && (!mq[i].ns || mq[i].rel)) cand.push_back(i);
    end
    for (int i = 1; i < cand.size(); i++) begin
      for (int j = i; j > 0; j--) begin
        if (older(mq[cand[j]].seq, mq[cand[j-1]].seq)) begin
          int t;
          t = cand[j]; cand[j] = cand[j-1]; cand[j-1] = t;
        end
      end
    end
    exp_n = 0;
    for (int i = 0; i < cand.size(); i++) begin
      int c;
      c = mq[cand[i]].cls;
      if (ccnt[c] < 1 && exp_n < IW) begin
        ccnt[c]++;
        exp_seq[exp_n] = mq[cand[i]].seq;
        exp_tag[exp_n] = mq[cand[i]].dst;
        rm[cand[i]] = 1;
        exp_n++;
      end
    end
    for (int i = mq.size() - 1; i >= 0; i--) if (rm[i]) mq.delete(i);
    for (int i = 0; i < mq.size(); i++) begin
      if (wk_valid && mq[i].t0 == int'(wk_tag)) mq[i].r0 = 1;
      if (wk_valid && mq[i].t1 == int'(wk_tag)) mq[i].r1 = 1;
      if (rel_valid && mq[i].ns && mq[i].seq == int'(rel_seq)) mq[i].rel = 1;
    end
    if (acc) begin
      e.seq = ins_seq; e.cls = ins_cls; e.ns = ins_nonspec; e.rel = 0;
      e.t0 = ins_s0_tag; e.t1 = ins_s1_tag; e.dst = ins_dst_tag;
      e.r0 = !ins_s0_valid || msb[ins_s0_tag] || (wk_valid && wk_tag == ins_s0_tag);
      e.r1 = !ins_s1_valid || msb[ins_s1_tag] || (wk_valid && wk_tag == ins_s1_tag);
      mq.push_back(e);
    end
    if (wk_valid) msb[wk_tag] = 1;
    if (acc && ins_dst_valid) msb[ins_dst_tag] = 0;
  endtask

  task automatic step(string req);
    model_step();
    @(posedge clk);
    @(negedge clk);
    for (int s = 0; s < IW; s++) begin
      check(req, $sformatf("iss_valid[%0d]", s), int'(iss_valid[s]), int'(s < exp_n));
      if (s < exp_n) begin
        check(req, $sformatf("iss_seq[%0d]", s), int'(iss_seq[s*8 +: 8]), exp_seq[s]);
        check(req, $sformatf("iss_tag[%0d]", s), int'(iss_tag[s*5 +: 5]), exp_tag[s]);
      end
    end
    check(req, "free_cnt", int'(free_cnt), N - mq.size());
    check(req, "full", int'(full), int'(mq.size() == N));
    ins_valid = 0; ins_nonspec = 0; ins_s0_valid = 0; ins_s1_valid = 0; ins_dst_valid = 0;
    wk_valid = 0; rel_valid = 0; sq_valid = 0;
  endtask

  task automatic put(int seq, int cls, bit s0v, int s0, bit s1v, int s1, bit dv, int d, bit ns);
    ins_valid = 1; ins_seq = 8'(seq); ins_cls = 2'(cls);
    ins_s0_valid = s0v; ins_s0_tag = 5'(s0);
    ins_s1_valid = s1v; ins_s1_tag = 5'(s1);
    ins_dst_valid = dv; ins_dst_tag = 5'(d); ins_nonspec = ns;
  endtask

  task automatic wake(int t);
    wk_valid = 1; wk_tag = 5'(t);
  endtask

  initial begin
    for (int i = 0; i < PREGS; i++) msb[i] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check("R1", "free_cnt", int'(free_cnt), 8);
    check("R1", "full", int'(full), 0);
    check("R1", "iss_valid", int'(iss_valid), 0);
    step("R1");

    // R2: ready instruction issues one edge after insertion, for one cycle
    put(10, 0, 0, 0, 0, 0, 1, 1, 0); step("R2");
    step("R2");
    step("R2");

    // R5: tag 1 is pending; two consumers wait, then one broadcast wakes both
    put(11, 0, 1, 1, 0, 0, 1, 2, 0); step("R5");
    put(12, 1, 1, 1, 1, 20, 1, 3, 0); step("R5");
    step("R5");
    step("R5");
    wake(1); step("R5");
    step("R5");
    step("R5");

    // R6: broadcast in the insert cycle
    put(13, 0, 1, 2, 0, 0, 1, 4, 0); wake(2); step("R6");
    step("R6");

    // R7: non-speculative hold and release by sequence number
    put(14, 3, 0, 0, 0, 0, 1, 5, 1); step("R7");
    step("R7");
    step("R7");
    rel_valid = 1; rel_seq = 99; step("R7");
    step("R7");
    rel_valid = 1; rel_seq = 14; step("R7");
    step("R7");
    step("R7");

    // R3/R4: eight waiting entries across a sequence wrap, inserted out of order
    put(0,   0, 1, 3, 0, 0, 1, 6,  0); step("R3");
    put(251, 0, 1, 3, 0, 0, 1, 7,  0); step("R3");
    put(254, 1, 1, 3, 0, 0, 1, 8,  0); step("R3");
    put(250, 0, 1, 3, 0, 0, 1, 9,  0); step("R3");
    put(1,   2, 0, 0, 1, 3, 1, 10, 0); step("R3");
    put(253, 2, 1, 3, 0, 0, 1, 11, 0); step("R3");
    put(255, 3, 1, 3, 0, 0, 1, 12, 0); step("R3");
    put(252, 1, 1, 3, 0, 0, 1, 13, 0); step("R9");
    // R9: insert refused while full
    put(2, 0, 0, 0, 0, 0, 1, 14, 0); step("R9");
    check("R9", "full after refused insert", int'(full), 1);
    wake(3); step("R4");
    for (int k = 0; k < 6; k++) step("R4");

    // R8: squash removes younger waiting entries and drops the concurrent insert
    for (int s = 20; s < 26; s++) begin
      put(s, s % 4, 1, 4, 0, 0, 1, 15, 0); step("R8");
    end
    sq_valid = 1; sq_seq = 22; put(26, 0, 0, 0, 0, 0, 1, 16, 0); step("R8");
    check("R8", "free_cnt after squash", int'(free_cnt), 5);
    wake(4); step("R8");
    for (int k = 0; k < 4; k++) step("R8");

    // R8: a ready entry squashed in the cycle it would issue does not issue
    put(30, 0, 0, 0, 0, 0, 1, 17, 0); step("R8");
    put(31, 0, 0, 0, 0, 0, 1, 18, 0); step("R8");
    sq_valid = 1; sq_seq = 30; step("R8");
    check("R8", "squashed entry not issued", int'(iss_valid), 0);
    step("R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run complete)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule